// File: doc/BRIEF.md
# HDLC Receiver with Address Filter

This block takes a serial bit stream made of the bits carried in a programmable set of E1 time slots and recovers HDLC/LAPD frames from it. A bit enters the receiver only when its strobe is high and the mask bit of its time slot is set. The receiver finds the frame delimiters and drops the zero bits that the sender inserted. It checks the 16-bit frame check sequence and keeps or drops each frame according to its leading address byte. The address filter works in one of two modes. In one-byte mode the first byte must match one of two programmable values. In two-byte mode the first (high) byte may also match the fixed group value, and the second byte is not compared. In every comparison bit 1 of the address byte is the command/response bit and does not take part.

A kept frame is written into a 64-entry receive FIFO without its two check bytes, and a status byte follows it. An interrupt pulse marks the end of each message. A second interrupt pulse fires each time another 32 bytes have been written. A transparent mode skips all frame handling: every selected bit is packed into bytes and stored as it arrives.

Top module: `hdlc_addr_rx`

## Requirements
- R1: A bit is taken only in a cycle where `bit_en` is high and `slot_mask[slot_idx]` is 1; bits in other cycles have no effect on FIFO contents.
- R2: A 0 followed by six 1s and a 0 (0x7E, sent LSB first) opens and closes frames. Back-to-back flags store nothing. A 0 that follows five consecutive 1s inside a frame is removed. Data bytes are assembled LSB first.
- R3: The check sequence is a reflected CRC-16 with polynomial 0x8408 and an all-ones start value, computed over every byte including the two check bytes; the frame passes when the result equals 0xF0B8.
- R4: In one-byte mode a frame is kept only if its first byte with bit 1 cleared equals `addr_a` or `addr_b` with bit 1 cleared. A dropped frame writes nothing and raises no interrupt.
- R5: In two-byte mode the first byte is also kept when it equals 0xFC with bit 1 cleared (so 0xFC and 0xFE). The second byte is never compared.
- R6: A kept frame stores all its bytes except the last two, then one status byte. Status bit 7 = check passed and length valid, bit 6 = aborted, bit 5 = length error, bits 4..0 = 0.
- R7: A frame of fewer than 4 bytes, or one whose bit count between flags is not a multiple of 8, gets status bit 5 set and bit 7 clear.
- R8: Seven consecutive 1s abort the frame. A kept frame that has at least one byte gets status 0x40, and the bytes still held back are dropped. Reception then ignores all bits until the next flag.
- R9: In transparent mode every selected bit is packed LSB first into bytes of 8 and stored with no flag, zero-removal, CRC or status handling, and `irq_msg_end` stays low.
- R10: `irq_msg_end` is a one-cycle pulse in the cycle in which a status byte becomes visible in the FIFO.
- R11: `irq_pool_full` is a one-cycle pulse after every 32nd byte accepted into the FIFO since reset. A dropped write is not counted.
- R12: The FIFO holds 64 bytes and presents its oldest byte on `rd_data`. A write to a full FIFO is dropped, and a read of an empty FIFO is ignored.
- R13: After reset the FIFO is empty, `fifo_cnt` is 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| bit_in | input | 1 | Received line bit |
| bit_en | input | 1 | Strobe marking a valid bit this cycle |
| slot_idx | input | 5 | Time slot the current bit belongs to |
| slot_mask | input | 32 | Per-slot enable mask |
| cfg_transparent | input | 1 | 1 = raw byte capture, no frame handling |
| cfg_addr2 | input | 1 | 1 = two-byte address mode |
| addr_a | input | 8 | First programmable address |
| addr_b | input | 8 | Second programmable address |
| rd_en | input | 1 | Pop the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte |
| fifo_cnt | output | 7 | Bytes held in the FIFO |
| fifo_empty | output | 1 | FIFO holds nothing |
| irq_msg_end | output | 1 | Status byte written |
| irq_pool_full | output | 1 | Another 32 bytes written |

## Verification
The status byte of a frame can be the write that completes a 32-byte group, so the end-of-message and pool-threshold pulses can rise in the same cycle. The bench provokes this by sending, right after reset, a kept frame that stores 31 bytes ahead of its status byte. A monitor counts cycles where both pulses are high, and the test expects exactly one such cycle and one pulse of each kind. The overflow case also meets the threshold logic: writes dropped while the FIFO is full must not advance the 32-byte count.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [7:0]  GROUP_ADDR = 8'hFC;
    localparam logic [7:0]  CR_MASK    = 8'hFD;

    typedef struct packed {
        logic       byte_vld;
        logic [7:0] data;
        logic       frm_end;
        logic       frm_odd;
        logic       frm_abort;
    } rx_evt_t;

    function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic addr_hit(logic [7:0] d, logic [7:0] a, logic [7:0] b, logic two);
        logic [7:0] m;
        m = d & CR_MASK;
        return (m == (a & CR_MASK)) || (m == (b & CR_MASK)) ||
               (two && (m == (GROUP_ADDR & CR_MASK)));
    endfunction

endpackage

// File: rtl/hdlc_bit_deframer.sv
module hdlc_bit_deframer
    import hdlc_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bit_vld,
    input  logic    bit_in,
    input  logic    transparent,
    output rx_evt_t evt
);

    typedef struct packed {
        logic [2:0]  ones;
        logic        hunting;
        logic [3:0]  nbits;
        logic [15:0] sh;
        logic [2:0]  tcnt;
        rx_evt_t     evt;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.evt = '0;
        if (bit_vld) begin
            if (transparent) begin
                s_d.sh   = {bit_in, s_q.sh[15:1]};
                s_d.tcnt = s_q.tcnt + 3'd1;
                if (s_q.tcnt == 3'd7) begin
                    s_d.evt.byte_vld = 1'b1;
                    s_d.evt.data     = s_d.sh[15:8];
                end
            end else begin
                s_d.ones = bit_in ? ((s_q.ones == 3'd7) ? 3'd7 : s_q.ones + 3'd1) : 3'd0;
                if (!bit_in && s_q.ones == 3'd6) begin
                    // delimiter: the data path holds 7 delimiter bits
                    if (!s_q.hunting && s_q.nbits >= 4'd8) begin
                        s_d.evt.frm_end = 1'b1;
                        s_d.evt.frm_odd = (s_q.nbits[2:0] != 3'd7);
                    end
                    s_d.hunting = 1'b0;
                    s_d.nbits   = 4'd0;
                end else if (bit_in && s_q.ones == 3'd6) begin
                    if (!s_q.hunting) begin
                        s_d.evt.frm_abort = 1'b1;
                    end
                    s_d.hunting = 1'b1;
                end else if (!bit_in && s_q.ones == 3'd5) begin
                    s_d.sh = s_q.sh;
                end else if (!s_q.hunting) begin
                    s_d.sh    = {bit_in, s_q.sh[15:1]};
                    s_d.nbits = (s_q.nbits == 4'd15) ? 4'd8 : s_q.nbits + 4'd1;
                    if (s_d.nbits == 4'd15) begin
                        s_d.evt.byte_vld = 1'b1;
                        s_d.evt.data     = s_d.sh[8:1];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.hunting <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign evt = s_q.evt;

    // R2
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.byte_vld, evt.frm_end, evt.frm_abort}));

    // R8
    abort_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.frm_abort && !transparent) |=> !evt.byte_vld);

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       wr_done
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_q, s_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        s_d   = s_q;
        do_wr = wr_en && (s_q.cnt != FULL);
        do_rd = rd_en && (s_q.cnt != '0);
        if (do_wr) s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + 1'b1;
        if (do_rd) s_d.rp = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[s_q.wp] <= wr_data;
    end

    assign rd_data = mem_q[s_q.rp];
    assign count   = s_q.cnt;
    assign empty   = (s_q.cnt == '0);
    assign wr_done = do_wr;

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == FULL && wr_en && !rd_en) |=> (s_q.cnt == FULL));

    // R12
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0 && rd_en && !wr_en) |=> (s_q.cnt == '0));

endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
    import hdlc_rx_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int DEPTH = 64,
    parameter int POOL  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_in,
    input  logic                       bit_en,
    input  logic [$clog2(SLOTS)-1:0]   slot_idx,
    input  logic [SLOTS-1:0]           slot_mask,
    input  logic                       cfg_transparent,
    input  logic                       cfg_addr2,
    input  logic [7:0]                 addr_a,
    input  logic [7:0]                 addr_b,
    input  logic                       rd_en,
    output logic [7:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
    output logic                       fifo_empty,
    output logic                       irq_msg_end,
    output logic                       irq_pool_full
);

    localparam int PW = $clog2(POOL);
    localparam logic [PW-1:0] POOL_LAST = PW'(POOL - 1);

    typedef struct packed {
        logic          accept;
        logic [2:0]    nbytes;
        logic [15:0]   crc;
        logic [7:0]    p0;
        logic [7:0]    p1;
        logic [1:0]    pv;
        logic [PW-1:0] wcnt;
        logic          irq_me;
        logic          irq_pf;
    } st_t;

    st_t      s_q, s_d;
    rx_evt_t  evt;
    logic     bit_take;
    logic     fifo_wr, fifo_wr_done, keep, len_err;
    logic [7:0] fifo_wd;

    assign bit_take = bit_en && slot_mask[slot_idx];

    hdlc_bit_deframer u_deframer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_vld     (bit_take),
        .bit_in      (bit_in),
        .transparent (cfg_transparent),
        .evt         (evt)
    );

    always_comb begin
        s_d        = s_q;
        s_d.irq_me = 1'b0;
        s_d.irq_pf = 1'b0;
        fifo_wr    = 1'b0;
        fifo_wd    = 8'h00;
        keep       = s_q.accept;
        len_err    = evt.frm_odd || (s_q.nbytes < 3'd4);
        if (cfg_transparent) begin
            if (evt.byte_vld) begin
                fifo_wr = 1'b1;
                fifo_wd = evt.data;
            end
        end else if (evt.byte_vld) begin
            if (s_q.nbytes == 3'd0) begin
                keep = addr_hit(evt.data, addr_a, addr_b, cfg_addr2);
            end
            s_d.accept = keep;
            s_d.crc    = crc16_step(s_q.crc, evt.data);
            s_d.nbytes = (s_q.nbytes == 3'd4) ? 3'd4 : s_q.nbytes + 3'd1;
            s_d.p0     = evt.data;
            s_d.p1     = s_q.p0;
            s_d.pv     = (s_q.pv == 2'd2) ? 2'd2 : s_q.pv + 2'd1;
            if (s_q.pv == 2'd2 && keep) begin
                fifo_wr = 1'b1;
                fifo_wd = s_q.p1;
            end
        end else if (evt.frm_end || evt.frm_abort) begin
            if (s_q.accept && s_q.nbytes != 3'd0) begin
                fifo_wr    = 1'b1;
                fifo_wd    = evt.frm_abort ? 8'h40 :
                             {(s_q.crc == CRC_GOOD) && !len_err, 1'b0, len_err, 5'b0};
                s_d.irq_me = 1'b1;
            end
            s_d.accept = 1'b0;
            s_d.nbytes = 3'd0;
            s_d.crc    = 16'hFFFF;
            s_d.pv     = 2'd0;
        end
        if (fifo_wr_done) begin
            s_d.wcnt   = (s_q.wcnt == POOL_LAST) ? '0 : s_q.wcnt + 1'b1;
            s_d.irq_pf = (s_q.wcnt == POOL_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.crc <= 16'hFFFF;
        end else begin
            s_q <= s_d;
        end
    end

    hdlc_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr),
        .wr_data (fifo_wd),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .count   (fifo_cnt),
        .empty   (fifo_empty),
        .wr_done (fifo_wr_done)
    );

    assign irq_msg_end   = s_q.irq_me;
    assign irq_pool_full = s_q.irq_pf;

    // R4
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_transparent && !s_q.accept && s_q.nbytes != 3'd0) |-> !fifo_wr);

    // R10
    msg_end_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_end |-> $past(s_q.accept));

    // R11
    pool_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pool_full |-> $past(fifo_wr_done));

    // R9
    raw_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_transparent && $past(cfg_transparent)) |-> !irq_msg_end);

endmodule

// File: tb/tb_hdlc_addr_rx.sv
module tb_hdlc_addr_rx;

    localparam int SEL = 1;
    localparam int OFF = 4;

    logic        clk = 1'b0;
    logic        rst_n, bit_in, bit_en, cfg_transparent, cfg_addr2, rd_en;
    logic [4:0]  slot_idx;
    logic [31:0] slot_mask;
    logic [7:0]  addr_a, addr_b, rd_data;
    logic [6:0]  fifo_cnt;
    logic        fifo_empty, irq_msg_end, irq_pool_full;

    int n_chk = 0, n_err = 0;
    int me_cnt = 0, pf_cnt = 0, both_cnt = 0;
    int tx_ones = 0;
    int fl = 0;
    logic [7:0] fb [0:63];

    always #10 clk = ~clk;

    hdlc_addr_rx dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
        .slot_idx(slot_idx), .slot_mask(slot_mask),
        .cfg_transparent(cfg_transparent), .cfg_addr2(cfg_addr2),
        .addr_a(addr_a), .addr_b(addr_b), .rd_en(rd_en),
        .rd_data(rd_data), .fifo_cnt(fifo_cnt), .fifo_empty(fifo_empty),
        .irq_msg_end(irq_msg_end), .irq_pool_full(irq_pool_full)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (irq_msg_end) me_cnt++;
            if (irq_pool_full) pf_cnt++;
            if (irq_msg_end && irq_pool_full) both_cnt++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset(bit tr, bit two);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; rd_en = 1'b0;
        slot_idx = 5'(SEL); slot_mask = 32'h0000_000F;
        cfg_transparent = tr; cfg_addr2 = two;
        addr_a = 8'h12; addr_b = 8'h55;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tx_ones = 0;
        @(negedge clk);
    endtask

    task automatic send_raw(bit b, int slot);
        @(negedge clk);
        bit_in = b; bit_en = 1'b1; slot_idx = 5'(slot);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_raw((i != 0) && (i != 7), SEL);
        tx_ones = 0;
    endtask

    task automatic send_dbit(bit b);
        send_raw(b, SEL);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0, SEL);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_dbyte(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_dbit(v[i]);
    endtask

    task automatic send_rawbyte(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_raw(v[i], SEL);
    endtask

    function automatic logic [15:0] calc_fcs(int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            c = c ^ {8'h00, fb[k]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic send_body(bit bad);
        logic [15:0] f;
        f = calc_fcs(fl);
        if (bad) f = f ^ 16'h0001;
        for (int k = 0; k < fl; k++) send_dbyte(fb[k]);
        send_dbyte(f[7:0]);
        send_dbyte(f[15:8]);
    endtask

    task automatic send_frame(bit bad);
        send_flag();
        send_body(bad);
        send_flag();
        idle(4);
    endtask

    task automatic pop_chk(string tag, logic [7:0] exp);
        @(negedge clk);
        chk(tag, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        apply_reset(1'b0, 1'b0);
        chk("R13 count", fifo_cnt, 0);
        chk("R13 empty", fifo_empty, 1);
        chk("R13 irq_msg_end", irq_msg_end, 0);
        chk("R13 irq_pool_full", irq_pool_full, 0);
    endtask

    task automatic t_good();
        int m0;
        apply_reset(1'b0, 1'b0);
        m0 = me_cnt;
        send_flag();
        fb[0] = 8'h10; fb[1] = 8'h03; fb[2] = 8'hFF; fb[3] = 8'h7E; fb[4] = 8'h3F; fl = 5;
        send_frame(1'b0);
        chk("R6 count after stuffed frame", fifo_cnt, 6);
        chk("R10 msg end pulses", me_cnt - m0, 1);
        for (int k = 0; k < 5; k++) pop_chk("R2 destuffed byte", fb[k]);
        pop_chk("R3 status ok", 8'h80);
        fb[0] = 8'h57; fb[1] = 8'h01; fb[2] = 8'h02; fl = 3;
        send_frame(1'b0);
        chk("R4 addr_b kept count", fifo_cnt, 4);
        for (int k = 0; k < 3; k++) pop_chk("R4 addr_b byte", fb[k]);
        pop_chk("R6 status", 8'h80);
    endtask

    task automatic t_reject();
        int m0;
        apply_reset(1'b0, 1'b0);
        m0 = me_cnt;
        fb[0] = 8'h44; fb[1] = 8'h01; fb[2] = 8'h02; fl = 3;
        send_frame(1'b0);
        chk("R4 rejected count", fifo_cnt, 0);
        chk("R4 rejected irq", me_cnt - m0, 0);
        fb[0] = 8'hFC; fl = 3;
        send_frame(1'b0);
        chk("R5 group ignored in one-byte mode", fifo_cnt, 0);
    endtask

    task automatic t_two();
        apply_reset(1'b0, 1'b1);
        fb[0] = 8'hFE; fb[1] = 8'h77; fb[2] = 8'h99; fl = 3;
        send_frame(1'b0);
        fb[0] = 8'hFC; fb[1] = 8'h31; fb[2] = 8'h00; fl = 3;
        send_frame(1'b0);
        fb[0] = 8'hFD; fl = 3;
        send_frame(1'b0);
        chk("R5 two-byte count", fifo_cnt, 8);
        pop_chk("R5 FE kept", 8'hFE); pop_chk("R5 low byte", 8'h77);
        pop_chk("R5 data", 8'h99);    pop_chk("R5 status", 8'h80);
        pop_chk("R5 FC kept", 8'hFC); pop_chk("R5 low byte", 8'h31);
        pop_chk("R5 data", 8'h00);    pop_chk("R5 status", 8'h80);
    endtask

    task automatic t_badcrc();
        apply_reset(1'b0, 1'b0);
        fb[0] = 8'h12; fb[1] = 8'hA0; fb[2] = 8'h0B; fl = 3;
        send_frame(1'b1);
        chk("R3 bad crc count", fifo_cnt, 4);
        for (int k = 0; k < 3; k++) pop_chk("R3 bad crc byte", fb[k]);
        pop_chk("R3 bad crc status", 8'h00);
    endtask

    task automatic t_short_odd();
        apply_reset(1'b0, 1'b0);
        fb[0] = 8'h12; fl = 1;
        send_frame(1'b0);
        chk("R7 short count", fifo_cnt, 2);
        pop_chk("R7 short byte", 8'h12);
        pop_chk("R7 short status", 8'h20);
        fb[0] = 8'h12; fb[1] = 8'h05; fb[2] = 8'h06; fl = 3;
        send_flag();
        send_body(1'b0);
        send_dbit(1'b0); send_dbit(1'b1); send_dbit(1'b0);
        send_flag();
        idle(4);
        chk("R7 odd count", fifo_cnt, 4);
        for (int k = 0; k < 3; k++) pop_chk("R7 odd byte", fb[k]);
        pop_chk("R7 odd status", 8'h20);
    endtask

    task automatic t_abort();
        int m0;
        apply_reset(1'b0, 1'b0);
        m0 = me_cnt;
        send_flag();
        send_dbyte(8'h12); send_dbyte(8'h01); send_dbyte(8'h02); send_dbyte(8'h01);
        for (int i = 0; i < 8; i++) send_raw(1'b1, SEL);
        for (int i = 0; i < 20; i++) send_raw(i % 3 == 0, SEL);
        fb[0] = 8'h12; fb[1] = 8'h09; fb[2] = 8'h0A; fl = 3;
        send_frame(1'b0);
        chk("R8 abort count", fifo_cnt, 6);
        chk("R8 abort irq", me_cnt - m0, 2);
        pop_chk("R8 byte before abort", 8'h12);
        pop_chk("R8 abort status", 8'h40);
        for (int k = 0; k < 3; k++) pop_chk("R8 recovered byte", fb[k]);
        pop_chk("R8 recovered status", 8'h80);
    endtask

    task automatic t_transparent();
        int m0;
        apply_reset(1'b1, 1'b0);
        m0 = me_cnt;
        send_rawbyte(8'hA5); send_rawbyte(8'h7E); send_rawbyte(8'hFF);
        idle(4);
        chk("R9 raw count", fifo_cnt, 3);
        chk("R9 no msg end", me_cnt - m0, 0);
        pop_chk("R9 raw byte", 8'hA5);
        pop_chk("R9 raw flag kept", 8'h7E);
        pop_chk("R9 raw ones kept", 8'hFF);
    endtask

    task automatic t_slot();
        logic [7:0] v;
        apply_reset(1'b1, 1'b0);
        v = 8'h3C;
        for (int i = 0; i < 8; i++) begin
            send_raw(v[i], SEL);
            send_raw(1'b1, OFF);
            @(negedge clk);
            bit_en = 1'b0; bit_in = 1'b0;
        end
        idle(4);
        chk("R1 masked slot count", fifo_cnt, 1);
        pop_chk("R1 masked slot byte", v);
    endtask

    task automatic t_full();
        int p0;
        apply_reset(1'b1, 1'b0);
        p0 = pf_cnt;
        for (int i = 0; i < 70; i++) send_rawbyte(8'(i));
        idle(4);
        chk("R12 full count", fifo_cnt, 64);
        chk("R11 pool pulses", pf_cnt - p0, 2);
        for (int i = 0; i < 64; i++) pop_chk("R12 order kept", 8'(i));
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk("R12 empty read count", fifo_cnt, 0);
        chk("R12 empty flag", fifo_empty, 1);
        send_rawbyte(8'h5A);
        idle(4);
        chk("R12 count after refill", fifo_cnt, 1);
        pop_chk("R12 byte after refill", 8'h5A);
    endtask

    task automatic t_same_cycle();
        int m0, p0, b0;
        apply_reset(1'b0, 1'b0);
        m0 = me_cnt; p0 = pf_cnt; b0 = both_cnt;
        fb[0] = 8'h12;
        for (int k = 1; k < 31; k++) fb[k] = 8'(k * 7);
        fl = 31;
        send_frame(1'b0);
        chk("R10 msg end once", me_cnt - m0, 1);
        chk("R11 pool once", pf_cnt - p0, 1);
        chk("R10 R11 same cycle", both_cnt - b0, 1);
        chk("R6 count 32", fifo_cnt, 32);
    endtask

    initial begin
        t_reset();
        t_good();
        t_reject();
        t_two();
        t_badcrc();
        t_short_odd();
        t_abort();
        t_transparent();
        t_slot();
        t_full();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule